// File: doc/BRIEF.md
# Serial Memory Slave Command Front-End

This block is the slave side of a four-wire serial memory link (SPI mode 0). It turns the select, clock, data-in and pause pins into commands for a small byte-wide storage array that it holds internally. Commands are one opcode byte, sent most significant bit first. They set and clear a write-enable latch, read a status byte, read the array from a 16-bit start address with auto-increment, and write a page of bytes. A host drives select low, clocks a command in, and for reads collects the reply bytes on the data-out pin. The data-out pin is a tri-state output, so its enable is a separate port.

All pins are assumed to be synchronous to the system clock and much slower than it. Edges on select, the serial clock and the pause pin are found by comparing each pin with its value one system clock earlier. A write is held in a page buffer and is placed into the array only when select rises on a byte boundary while the write-enable latch is set. After that, a busy window of a parameterized number of system clocks follows. During the window the array is updated and only status reads are answered. The pause pin freezes a transfer without losing its place.

Top module: `spimem_slave`

## Requirements
- R1: While reset is active and just after it, so_oe is 0 and the write-enable latch is clear, so a status read returns 0x00.
- R2: A command starts only on a high-to-low edge of cs_n seen after reset. Bits clocked while cs_n has stayed low since reset do nothing.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. No other command sets it.
- R4: A write command (opcode 0x02) issued while the write-enable latch is clear leaves the array and the status unchanged.
- R5: A write commits only if cs_n rises after a whole number of data bytes. A rise at any other bit count leaves the array unchanged, starts no busy window and keeps the latch set.
- R6: Opcode 0x03 followed by a 16-bit address, MSB first, returns array bytes on so, MSB first, from that address. Only the low log2(MEM_DEPTH) address bits are used, and the address increments after each byte and wraps at MEM_DEPTH.
- R7: Opcode 0x05 returns the status byte {6'b0, write-enable latch (bit 1), busy (bit 0)}, MSB first, and repeats it for as long as clocks continue.
- R8: so_oe is 0 during the opcode and address bits and while cs_n is high. It is 1 in the reply phase, which begins at the sck falling edge after the last command bit. so changes only after sck falling edges.
- R9: A falling edge on hold_n pauses the transfer only if sck is low at that edge. The pause ends only on a rising edge of hold_n with sck low. While paused, sck and si are ignored and so_oe is 0.
- R10: An unknown opcode makes the rest of the transfer be ignored until cs_n rises.
- R11: A committed write stores each received byte at the start offset plus its index, modulo PAGE_BYTES, within the page that holds the start address. Busy (status bit 0) stays set for WIP_CYCLES system clocks, and the write-enable latch clears when busy ends.
- R12: While busy, every opcode except 0x05 is ignored: a read drives no reply (so_oe stays 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Select, active low |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in, sampled on sck rising |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |

## Verification
The hardest case to reach from the pins is a command that arrives during the busy window. The window is only open for a fixed number of system clocks after a commit, so the bench issues a status read and then a full array read right after the write, keeps each transfer short, and sizes the window so that both fall inside it. Pausing is reached by dropping hold_n mid-opcode and mid-reply with sck low, and by dropping it once with sck high to show that this edge is not taken as a pause. The bench clocks garbage while paused to show that those bits are lost.

// File: rtl/spimem_pkg.sv
// Shared opcodes and command phases for the serial memory slave.
// Assumes opcode values are fixed at build time.
package spimem_pkg;
    localparam logic [7:0] OP_WEN_SET = 8'h06;
    localparam logic [7:0] OP_WEN_CLR = 8'h04;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_WRITE   = 8'h02;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPCODE,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_STAT,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/spimem_pins.sv
// Pin edge detector and pause tracker.
// Assumes cs_n, sck and hold_n are synchronous to clk and slower than it.
// Gives select edges and the serial clock edges that count (selected, not paused).
module spimem_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic cs_fall,
    output logic cs_rise,
    output logic rise_ev,
    output logic fall_ev,
    output logic held
);
    logic cs_q;
    logic sck_q;
    logic hold_q;

    // Remember last pin values; cs starts "low" so a select held low at reset makes no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            sck_q  <= 1'b0;
            hold_q <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sck_q  <= sck;
            hold_q <= hold_n;
        end
    end

    // Enter or leave the paused state only on hold_n edges taken while sck is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (cs_n) begin
            held <= 1'b0;
        end else if (hold_q && !hold_n && !sck) begin
            held <= 1'b1;
        end else if (!hold_q && hold_n && !sck) begin
            held <= 1'b0;
        end
    end

    assign cs_fall = cs_q && !cs_n;
    assign cs_rise = !cs_q && cs_n;
    assign rise_ev = !cs_n && !held && sck && !sck_q;
    assign fall_ev = !cs_n && !held && !sck && sck_q;
endmodule

// File: rtl/spimem_array.sv
// Byte-wide storage with one synchronous write port and one combinational read port.
// Assumes DEPTH is a power of two; contents clear on reset.
module spimem_array #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    // Clear on reset, otherwise store one byte per enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spimem_busy.sv
// Busy window timer: runs CYCLES system clocks after a start pulse.
// Assumes start is not raised while busy. done pulses in the last busy cycle.
module spimem_busy #(
    parameter int CYCLES = 400,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    // Count through the window and drop busy at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

    assign done = busy && (cnt == LAST);
endmodule

// File: rtl/spimem_slave.sv
// Serial memory slave front-end (mode 0): decodes opcodes, shifts addresses and
// data, guards writes with a write-enable latch and commits a page on select rise.
// Assumes pins are synchronous to clk; PAGE_BYTES is a power of two dividing
// MEM_DEPTH; WIP_CYCLES >= PAGE_BYTES.
module spimem_slave #(
    parameter int MEM_DEPTH  = 64,
    parameter int PAGE_BYTES = 8,
    parameter int WIP_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    import spimem_pkg::*;

    localparam int AW = $clog2(MEM_DEPTH);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(WIP_CYCLES + 1);

    logic          cs_fall, cs_rise, rise_ev, fall_ev, held;
    phase_t        ph;
    logic [3:0]    bcnt;
    logic [6:0]    sh;
    logic          is_wr;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] addr_full;
    logic [AW-PW-1:0] wr_pg;
    logic [PW-1:0] wr_off;
    logic [7:0]    pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic          wany;
    logic          wel;
    logic          busy, done;
    logic [CW-1:0] bcyc;
    logic          start;
    logic [7:0]    op_now, byte_now, rdata, cur_byte, status;
    logic [2:0]    tx_idx;
    logic          drv;
    logic          so_r;
    logic          wr_en;
    logic [PW-1:0] wslot;

    spimem_pins u_pins (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .rise_ev(rise_ev),
        .fall_ev(fall_ev), .held(held)
    );

    spimem_busy #(.CYCLES(WIP_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .cnt(bcyc)
    );

    assign wslot = bcyc[PW-1:0];
    assign wr_en = busy && (bcyc < CW'(PAGE_BYTES)) && pmask[wslot];

    spimem_array #(.DEPTH(MEM_DEPTH)) u_array (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr({wr_pg, wslot}),
        .wdata(pbuf[wslot]), .raddr(rd_addr), .rdata(rdata)
    );

    assign op_now    = {sh, si};
    assign byte_now  = {sh, si};
    assign addr_full = {rd_addr[AW-2:0], si};
    assign status    = {6'b0, wel, busy};
    assign cur_byte  = (ph == PH_STAT) ? status : rdata;
    assign start     = cs_rise && (ph == PH_WDATA) && (bcnt == 4'd0)
                       && wany && wel && !busy;

    // Command phase, bit counter, shifter and read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            bcnt    <= '0;
            sh      <= '0;
            is_wr   <= 1'b0;
            rd_addr <= '0;
        end else if (cs_fall) begin
            ph   <= PH_OPCODE;
            bcnt <= '0;
        end else if (cs_rise) begin
            ph <= PH_IDLE;
        end else if (rise_ev) begin
            sh <= {sh[5:0], si};
            case (ph)
                PH_OPCODE: begin
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == 4'd7) begin
                        bcnt <= '0;
                        if (busy && op_now != OP_STATUS) ph <= PH_SKIP;
                        else begin
                            case (op_now)
                                OP_STATUS: ph <= PH_STAT;
                                OP_READ:   begin ph <= PH_ADDR; is_wr <= 1'b0; end
                                OP_WRITE:  begin ph <= PH_ADDR; is_wr <= 1'b1; end
                                default:   ph <= PH_SKIP;
                            endcase
                        end
                    end
                end
                PH_ADDR: begin
                    rd_addr <= addr_full;
                    bcnt    <= bcnt + 1'b1;
                    if (bcnt == 4'd15) begin
                        bcnt <= '0;
                        ph   <= is_wr ? PH_WDATA : PH_RDATA;
                    end
                end
                PH_WDATA: bcnt <= (bcnt == 4'd7) ? 4'd0 : bcnt + 1'b1;
                default:  ;
            endcase
        end else if (fall_ev && ph == PH_RDATA && tx_idx == 3'd7) begin
            rd_addr <= rd_addr + 1'b1;
        end
    end

    // Write-enable latch: set or cleared by its opcodes, cleared when busy ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (done) begin
            wel <= 1'b0;
        end else if (rise_ev && ph == PH_OPCODE && bcnt == 4'd7 && !busy) begin
            if (op_now == OP_WEN_SET)      wel <= 1'b1;
            else if (op_now == OP_WEN_CLR) wel <= 1'b0;
        end
    end

    // Page buffer: cleared when a write address completes, filled byte by byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pg  <= '0;
            wr_off <= '0;
            pmask  <= '0;
            wany   <= 1'b0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
        end else if (rise_ev && ph == PH_ADDR && bcnt == 4'd15 && is_wr) begin
            wr_pg  <= addr_full[AW-1:PW];
            wr_off <= addr_full[PW-1:0];
            pmask  <= '0;
            wany   <= 1'b0;
        end else if (rise_ev && ph == PH_WDATA && bcnt == 4'd7) begin
            pbuf[wr_off]  <= byte_now;
            pmask[wr_off] <= 1'b1;
            wr_off        <= wr_off + 1'b1;
            wany          <= 1'b1;
        end
    end

    // Reply shifter: drive the next bit after each sck falling edge in a reply phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so_r   <= 1'b0;
            tx_idx <= '0;
            drv    <= 1'b0;
        end else if (cs_fall || cs_rise) begin
            tx_idx <= '0;
            drv    <= 1'b0;
        end else if (fall_ev && (ph == PH_RDATA || ph == PH_STAT)) begin
            drv    <= 1'b1;
            so_r   <= cur_byte[3'd7 - tx_idx];
            tx_idx <= tx_idx + 1'b1;
        end
    end

    assign so    = so_r;
    assign so_oe = drv && !held && (ph == PH_RDATA || ph == PH_STAT);
endmodule

// File: rtl/spimem_slave_chk.sv
// Property checker for the serial memory slave, attached by bind.
// Assumes the bound signal names of spimem_slave.
module spimem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic hold_n,
    input logic so,
    input logic so_oe,
    input logic busy,
    input logic wel
);
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe); // R8
    AST_SO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(so)); // R8
    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_n) && !sck && !cs_n) |=> !so_oe); // R9
    AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel)); // R3
    AST_COMMIT_ON_SELECT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_n)); // R5
    AST_WEL_DROPS_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R11
endmodule

bind spimem_slave spimem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .busy(busy), .wel(wel)
);

// File: tb/spimem_slave_tb.sv
// Bench: drives pins from tasks, keeps a behavioural model of the array,
// latch and busy window, and compares every reply bit and enable per clocked bit.
module spimem_slave_tb;
    localparam int DEPTH = 64;
    localparam int PAGE  = 8;
    localparam int WIP   = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    int   total = 0, bad = 0;
    bit   finished = 0;

    logic [7:0] mem_m [DEPTH];
    bit         wel_m = 0;
    bit         pend = 0;

    always #5 clk = ~clk;

    spimem_slave #(.MEM_DEPTH(DEPTH), .PAGE_BYTES(PAGE), .WIP_CYCLES(WIP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, output logic r, output logic oe);
        si = b;
        tick(1);
        r = so; oe = so_oe;
        sck = 1'b1; tick(2);
        sck = 1'b0; tick(2);
    endtask

    task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx, output int oec);
        logic r, oe;
        oec = 0;
        for (int i = 7; i >= 0; i--) begin
            bit_x(tx[i], r, oe);
            rx[i] = r;
            oec += int'(oe);
        end
    endtask

    task automatic cs_lo(); cs_n = 1'b0; tick(2); endtask
    task automatic cs_hi(); cs_n = 1'b1; tick(2); endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r; int oc;
        cs_lo(); byte_x(op, r, oc); cs_hi();
        if (op == 8'h06) wel_m = 1;
        if (op == 8'h04) wel_m = 0;
    endtask

    // Status read of two bytes; both must match the model (R7).
    task automatic rdsr_chk(input logic [7:0] exp, input string tag);
        logic [7:0] r; int oc;
        cs_lo();
        byte_x(8'h05, r, oc);
        chk({tag, " R8 no drive during opcode"}, oc, 0);
        byte_x(8'h00, r, oc);
        chk({tag, " R7 status"}, r, exp);
        chk({tag, " R8 drive in reply"}, oc, 8);
        byte_x(8'h00, r, oc);
        chk({tag, " R7 status repeats"}, r, exp);
        cs_hi();
    endtask

    task automatic rd_chk(input logic [15:0] a, input int n, input bit ignored, input string tag);
        logic [7:0] r; int oc, tot;
        cs_lo();
        byte_x(8'h03, r, oc); tot = oc;
        byte_x(a[15:8], r, oc); tot += oc;
        byte_x(a[7:0], r, oc); tot += oc;
        chk({tag, " R8 no drive in opcode/address"}, tot, 0);
        for (int i = 0; i < n; i++) begin
            byte_x(8'h00, r, oc);
            if (ignored) chk({tag, " R12 read ignored while busy"}, oc, 0);
            else begin
                chk({tag, " R6 read data"}, r, mem_m[(int'(a) + i) % DEPTH]);
                chk({tag, " R8 drive in data"}, oc, 8);
            end
        end
        cs_hi();
    endtask

    // Write n bytes (first byte in d[31:24]) then extra stray bits.
    task automatic wr(input logic [15:0] a, input int n, input logic [31:0] d, input int extra);
        logic [7:0] r; logic rb, ro; int oc;
        cs_lo();
        byte_x(8'h02, r, oc);
        byte_x(a[15:8], r, oc);
        byte_x(a[7:0], r, oc);
        for (int i = 0; i < n; i++) byte_x(d[31-8*i -: 8], r, oc);
        for (int i = 0; i < extra; i++) bit_x(1'b1, rb, ro);
        cs_hi();
        if (wel_m && extra == 0 && n > 0) begin
            for (int i = 0; i < n; i++) begin
                int base, off;
                base = (int'(a) % DEPTH) - (int'(a) % PAGE);
                off  = ((int'(a) % PAGE) + i) % PAGE;
                mem_m[base + off] = d[31-8*i -: 8];
            end
            pend = 1;
        end
    endtask

    task automatic wait_busy();
        tick(WIP + 10);
        if (pend) begin wel_m = 0; pend = 0; end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r; int oc; logic b, oe; logic [7:0] st;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
        tick(4);
        chk("R1 so_oe in reset", so_oe, 0);
        rst_n = 1'b1; tick(2);
        chk("R1 so_oe after reset", so_oe, 0);
        // R2: select low since reset, clock in 0x06: must be ignored
        byte_x(8'h06, r, oc);
        cs_hi();
        rdsr_chk(8'h00, "R2/R1");

        cmd1(8'h06); rdsr_chk(8'h02, "R3 set");
        cmd1(8'h04); rdsr_chk(8'h00, "R3 clear");

        wr(16'h0005, 1, 32'hA5000000, 0);
        rd_chk(16'h0005, 1, 0, "R4 guarded");
        rdsr_chk(8'h00, "R4 status");

        cmd1(8'h06);
        wr(16'h0010, 3, 32'h11223300, 0);
        rdsr_chk(8'h03, "R11 busy");
        rd_chk(16'h0010, 1, 1, "R12");
        wait_busy();
        rdsr_chk(8'h00, "R11 latch cleared");
        rd_chk(16'h0010, 3, 0, "R6 R11 burst");

        cmd1(8'h06);
        wr(16'h0006, 3, 32'h01020300, 0);
        wait_busy();
        rd_chk(16'h0006, 2, 0, "R11 page tail");
        rd_chk(16'h0000, 1, 0, "R11 page wrap");

        cmd1(8'h06);
        wr(16'h0020, 1, 32'h77000000, 3);
        rdsr_chk(8'h02, "R5 abort status");
        rd_chk(16'h0020, 1, 0, "R5 abort data");
        cmd1(8'h04);

        rd_chk(16'h003F, 2, 0, "R6 wrap");
        rd_chk(16'h1006, 1, 0, "R6 high bits");

        cs_lo(); byte_x(8'hA5, r, oc); byte_x(8'h06, r, oc);
        chk("R10 no drive", oc, 0);
        cs_hi();
        rdsr_chk(8'h00, "R10");

        // R9: pause mid-opcode, garbage bits ignored
        cs_lo();
        for (int i = 0; i < 4; i++) bit_x(1'b0, b, oe);
        hold_n = 1'b0; tick(2);
        chk("R9 paused no drive", so_oe, 0);
        bit_x(1'b1, b, oe); bit_x(1'b1, b, oe);
        hold_n = 1'b1; tick(2);
        bit_x(1'b0, b, oe); bit_x(1'b1, b, oe); bit_x(1'b1, b, oe); bit_x(1'b0, b, oe);
        cs_hi(); wel_m = 1;
        rdsr_chk(8'h02, "R9 resume opcode");

        // R9: pause mid-reply
        cs_lo(); byte_x(8'h05, r, oc);
        for (int i = 7; i >= 5; i--) begin bit_x(1'b0, b, oe); st[i] = b; end
        hold_n = 1'b0; tick(2);
        chk("R9 reply paused", so_oe, 0);
        bit_x(1'b0, b, oe); bit_x(1'b0, b, oe);
        hold_n = 1'b1; tick(2);
        chk("R9 reply resumed", so_oe, 1);
        for (int i = 4; i >= 0; i--) begin bit_x(1'b0, b, oe); st[i] = b; end
        chk("R9 status across pause", st, 8'h02);
        cs_hi();

        // R9: hold_n falling with sck high is not a pause
        cs_lo(); byte_x(8'h05, r, oc);
        sck = 1'b1; tick(2);
        hold_n = 1'b0; tick(2);
        sck = 1'b0; tick(2);
        chk("R9 high-sck edge not a pause", so_oe, 1);
        hold_n = 1'b1; tick(2);
        cs_hi();
        chk("R8 deselect quiet", so_oe, 0);
        cmd1(8'h04);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule